// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the privileged control registers of a processor core: 64-bit registers selected by a 7-bit index. One request per cycle arrives with a valid flag, an index, a write flag and write data. Each register has its own rules: some keep only certain bits of a write, some clear or set themselves whatever is written, some can only be read or only be written, and a few act as control commands that invalidate entries in the instruction or data translation buffers. A read of the cycle-count register merges its stored upper half with the low half of a live count supplied by the pipeline.

The response side is a small state machine with three named states: `RSP_IDLE` (no request was taken last cycle), `RSP_READ` (a read was taken) and `RSP_WRITE` (a write was taken). Every cycle the next state is chosen from the request: no valid gives the transition to `RSP_IDLE`, a valid read gives the transition to `RSP_READ`, a valid write gives the transition to `RSP_WRITE`; any state may move to any other. The response valid output is high in `RSP_READ` and `RSP_WRITE`. Invalidate strobes are registered alongside and last exactly one clock per triggering write.

Top module: `ctlreg_bank`

## Requirements
- R1: Synchronous active-high reset clears every register to zero, leaves the response state in `RSP_IDLE` with fault and read data zero, and holds all six flush strobes and the flush address and address-space outputs at zero.
- R2: Every request taken in cycle N produces `rsp_valid` in cycle N+1 with the fault flag and read data; a cycle without a request gives `rsp_valid` low. A read of a readable register returns its stored value, and a write response carries zero read data.
- R3: The 24 scratch registers at indices 0 to 23 store all 64 bits of a write and read them back unchanged.
- R4: On a write, the register keeps only these bits: exception address (index 24) all bits except bit 1; trap request (25) and trap enable (26) bits 3:0; priority level (27) bits 4:0; current mode (28) and alternate mode (29) mask 0x18; software interrupt request (30) mask 0x7FFF0; data address-space number (42) bits 63:57; instruction address-space number (43) mask 0x7F0; cache-mode registers (44, 45) bits 5:0.
- R5: Any write to the exception summary (31) or exception mask (32) register leaves it at zero, whatever the written data.
- R6: A read of the cycle-count register (33) returns its stored bits 63:32 above the 32-bit `cycles_lo` input value of the request cycle; a write to it stores all 64 bits.
- R7: A write to the cycle-count control register (34) sets it to 1 whatever the data; it is readable.
- R8: A write to a read-only register (35 interrupt ID, 36 translation status, 37 and 38 page-entry temporaries) gives a fault and changes nothing; reads of these return their value without fault.
- R9: A read of a write-only register (29 alternate mode, 39 interrupt clear, 40 and 41 cache flushes, 46 to 51 buffer invalidates) gives a fault and zero read data.
- R10: Any access to an index from 52 to 127 gives a fault on reads and on writes and changes no state.
- R11: A write to 46 (data invalidate all), 47 (data invalidate process), 48 (instruction invalidate all) or 49 (instruction invalidate process) stores zero and raises the matching strobe for exactly the one cycle after the request; at most one strobe is high in any cycle.
- R12: A write to 50 (data invalidate single) or 51 (instruction invalidate single) stores the data and, in the next cycle, raises the matching single-entry strobe with `flush_va` equal to the written data and `flush_asn` equal to bits 63:57 of register 42 (data) or bits 10:4 of register 43 (instruction).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_idx | input | 7 | Register index |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 64 | Write data |
| cycles_lo | input | 32 | Low half of the live cycle count |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_rdata | output | 64 | Read data (zero on fault or write) |
| rsp_fault | output | 1 | Illegal access |
| dtb_flush_all | output | 1 | Data buffer invalidate-all strobe |
| dtb_flush_proc | output | 1 | Data buffer invalidate-process strobe |
| dtb_flush_one | output | 1 | Data buffer single-entry strobe |
| itb_flush_all | output | 1 | Instruction buffer invalidate-all strobe |
| itb_flush_proc | output | 1 | Instruction buffer invalidate-process strobe |
| itb_flush_one | output | 1 | Instruction buffer single-entry strobe |
| flush_va | output | 64 | Address for a single-entry strobe |
| flush_asn | output | 7 | Address-space number for a single-entry strobe |

## Verification
The bound checker watches on every cycle that a response follows each request by exactly one cycle, that a faulting response carries zero data, that unmapped indices and writes to read-only registers fault, that strobes are mutually exclusive and trace back to a write of the matching index, and that a single-entry strobe carries the written address. Bit masks, clear-on-write and set-on-write effects, the merge of the live count, and the address-space number taken from the other registers are stored-state effects that only the bench's write-then-read scenarios, compared against its reference model, can show.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int IDX_W       = 7;
    localparam int DATA_W      = 64;
    localparam int CYC_LO_W    = 32;
    localparam int ASN_W       = 7;
    localparam int NUM_SCRATCH = 24;
    localparam int NUM_REGS    = 52;
    localparam int SLOT_W      = IDX_W - 1;
    localparam int BANK_DEPTH  = 2 ** SLOT_W;

    typedef enum logic [IDX_W-1:0] {
        CR_SCRATCH0     = 7'd0,
        CR_EXC_PC       = 7'd24,
        CR_AST_REQ      = 7'd25,
        CR_AST_EN       = 7'd26,
        CR_IRQ_LVL      = 7'd27,
        CR_CUR_MODE     = 7'd28,
        CR_ALT_MODE     = 7'd29,
        CR_SW_IRQ       = 7'd30,
        CR_EXC_SUM      = 7'd31,
        CR_EXC_MASK     = 7'd32,
        CR_CYC          = 7'd33,
        CR_CYC_CTL      = 7'd34,
        CR_IRQ_ID       = 7'd35,
        CR_MM_STAT      = 7'd36,
        CR_IPTE_TMP     = 7'd37,
        CR_DPTE_TMP     = 7'd38,
        CR_HWI_CLR      = 7'd39,
        CR_DC_FLUSH     = 7'd40,
        CR_IC_FLUSH     = 7'd41,
        CR_DTB_ASN      = 7'd42,
        CR_ITB_ASN      = 7'd43,
        CR_DC_MODE      = 7'd44,
        CR_MAF_MODE     = 7'd45,
        CR_DTB_INV_ALL  = 7'd46,
        CR_DTB_INV_PROC = 7'd47,
        CR_ITB_INV_ALL  = 7'd48,
        CR_ITB_INV_PROC = 7'd49,
        CR_DTB_INV_ONE  = 7'd50,
        CR_ITB_INV_ONE  = 7'd51
    } cr_idx_e;

    typedef enum logic [2:0] {
        WK_MASKED, WK_CLEAR, WK_SET_ONE, WK_ZERO_FLUSH, WK_KEEP_FLUSH
    } wkind_e;

    typedef enum logic [2:0] {
        FL_NONE, FL_DTB_ALL, FL_DTB_PROC, FL_DTB_ONE,
        FL_ITB_ALL, FL_ITB_PROC, FL_ITB_ONE
    } flush_e;

    typedef enum logic [1:0] {
        RSP_IDLE, RSP_READ, RSP_WRITE
    } rsp_state_e;

    typedef struct packed {
        logic              exists;
        logic              readable;
        logic              writable;
        logic              live_low;
        wkind_e            kind;
        flush_e            flush;
        logic [DATA_W-1:0] mask;
    } cr_attr_t;

endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
    import ctlreg_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output cr_attr_t         attr
);

    always_comb begin
        attr          = '0;
        attr.mask     = '1;
        attr.kind     = WK_MASKED;
        attr.flush    = FL_NONE;
        if (idx < IDX_W'(NUM_SCRATCH)) begin
            attr.exists   = 1'b1;
            attr.readable = 1'b1;
            attr.writable = 1'b1;
        end else begin
            unique case (idx)
                CR_EXC_PC, CR_AST_REQ, CR_AST_EN, CR_IRQ_LVL, CR_CUR_MODE,
                CR_SW_IRQ, CR_DTB_ASN, CR_ITB_ASN, CR_DC_MODE, CR_MAF_MODE,
                CR_EXC_SUM, CR_EXC_MASK, CR_CYC, CR_CYC_CTL: begin
                    attr.exists   = 1'b1;
                    attr.readable = 1'b1;
                    attr.writable = 1'b1;
                end
                CR_IRQ_ID, CR_MM_STAT, CR_IPTE_TMP, CR_DPTE_TMP: begin
                    attr.exists   = 1'b1;
                    attr.readable = 1'b1;
                end
                CR_ALT_MODE, CR_HWI_CLR, CR_DC_FLUSH, CR_IC_FLUSH,
                CR_DTB_INV_ALL, CR_DTB_INV_PROC, CR_ITB_INV_ALL,
                CR_ITB_INV_PROC, CR_DTB_INV_ONE, CR_ITB_INV_ONE: begin
                    attr.exists   = 1'b1;
                    attr.writable = 1'b1;
                end
                default: ;
            endcase

            unique case (idx)
                CR_EXC_PC:                 attr.mask = ~DATA_W'(64'h2);
                CR_AST_REQ, CR_AST_EN:     attr.mask = DATA_W'(64'hF);
                CR_IRQ_LVL:                attr.mask = DATA_W'(64'h1F);
                CR_CUR_MODE, CR_ALT_MODE:  attr.mask = DATA_W'(64'h18);
                CR_SW_IRQ:                 attr.mask = DATA_W'(64'h7FFF0);
                CR_DTB_ASN:                attr.mask = DATA_W'(64'hFE00_0000_0000_0000);
                CR_ITB_ASN:                attr.mask = DATA_W'(64'h7F0);
                CR_DC_MODE, CR_MAF_MODE:   attr.mask = DATA_W'(64'h3F);
                CR_EXC_SUM, CR_EXC_MASK:   attr.kind = WK_CLEAR;
                CR_CYC_CTL:                attr.kind = WK_SET_ONE;
                CR_CYC:                    attr.live_low = 1'b1;
                CR_DTB_INV_ALL:  begin attr.kind = WK_ZERO_FLUSH; attr.flush = FL_DTB_ALL;  end
                CR_DTB_INV_PROC: begin attr.kind = WK_ZERO_FLUSH; attr.flush = FL_DTB_PROC; end
                CR_ITB_INV_ALL:  begin attr.kind = WK_ZERO_FLUSH; attr.flush = FL_ITB_ALL;  end
                CR_ITB_INV_PROC: begin attr.kind = WK_ZERO_FLUSH; attr.flush = FL_ITB_PROC; end
                CR_DTB_INV_ONE:  begin attr.kind = WK_KEEP_FLUSH; attr.flush = FL_DTB_ONE;  end
                CR_ITB_INV_ONE:  begin attr.kind = WK_KEEP_FLUSH; attr.flush = FL_ITB_ONE;  end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ctlreg_flush.sv
module ctlreg_flush
    import ctlreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  flush_e            sel,
    input  logic [DATA_W-1:0] va,
    input  logic [ASN_W-1:0]  dtb_asn,
    input  logic [ASN_W-1:0]  itb_asn,
    output logic              dtb_all,
    output logic              dtb_proc,
    output logic              dtb_one,
    output logic              itb_all,
    output logic              itb_proc,
    output logic              itb_one,
    output logic [DATA_W-1:0] flush_va,
    output logic [ASN_W-1:0]  flush_asn
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dtb_all   <= 1'b0;
            dtb_proc  <= 1'b0;
            dtb_one   <= 1'b0;
            itb_all   <= 1'b0;
            itb_proc  <= 1'b0;
            itb_one   <= 1'b0;
            flush_va  <= '0;
            flush_asn <= '0;
        end else begin
            dtb_all   <= fire && (sel == FL_DTB_ALL);
            dtb_proc  <= fire && (sel == FL_DTB_PROC);
            dtb_one   <= fire && (sel == FL_DTB_ONE);
            itb_all   <= fire && (sel == FL_ITB_ALL);
            itb_proc  <= fire && (sel == FL_ITB_PROC);
            itb_one   <= fire && (sel == FL_ITB_ONE);
            flush_va  <= (fire && (sel == FL_DTB_ONE || sel == FL_ITB_ONE)) ? va : '0;
            flush_asn <= (fire && sel == FL_DTB_ONE) ? dtb_asn :
                         (fire && sel == FL_ITB_ONE) ? itb_asn : '0;
        end
    end

endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
    import ctlreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [IDX_W-1:0]    req_idx,
    input  logic                req_write,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [CYC_LO_W-1:0] cycles_lo,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_fault,
    output logic                dtb_flush_all,
    output logic                dtb_flush_proc,
    output logic                dtb_flush_one,
    output logic                itb_flush_all,
    output logic                itb_flush_proc,
    output logic                itb_flush_one,
    output logic [DATA_W-1:0]   flush_va,
    output logic [ASN_W-1:0]    flush_asn
);

    localparam int HI_W = DATA_W - CYC_LO_W;

    cr_attr_t          attr;
    rsp_state_e        state_q, state_d;
    logic [DATA_W-1:0] bank [BANK_DEPTH];
    logic [SLOT_W-1:0] slot;
    logic [DATA_W-1:0] rd_val, wr_val;
    logic              rd_ok, wr_ok, fault_d;

    ctlreg_decode u_decode (
        .idx  (req_idx),
        .attr (attr)
    );

    assign slot  = req_idx[SLOT_W-1:0];
    assign rd_ok = req_valid && !req_write && attr.exists && attr.readable;
    assign wr_ok = req_valid &&  req_write && attr.exists && attr.writable;
    assign fault_d = req_valid && !rd_ok && !wr_ok;

    always_comb begin
        rd_val = attr.live_low ? {bank[slot][DATA_W-1:CYC_LO_W], cycles_lo} : bank[slot];
        unique case (attr.kind)
            WK_CLEAR, WK_ZERO_FLUSH: wr_val = '0;
            WK_SET_ONE:              wr_val = DATA_W'(1);
            WK_KEEP_FLUSH:           wr_val = req_wdata;
            default:                 wr_val = req_wdata & attr.mask;
        endcase
    end

    // Next response state
    always_comb begin
        if (!req_valid)      state_d = RSP_IDLE;
        else if (req_write)  state_d = RSP_WRITE;
        else                 state_d = RSP_READ;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RSP_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_rdata <= '0;
            rsp_fault <= 1'b0;
            for (int i = 0; i < BANK_DEPTH; i++) bank[i] <= '0;
        end else begin
            rsp_rdata <= rd_ok ? rd_val : '0;
            rsp_fault <= fault_d;
            if (wr_ok) bank[slot] <= wr_val;
        end
    end

    // Output decode from the response state
    always_comb begin
        unique case (state_q)
            RSP_READ, RSP_WRITE: rsp_valid = 1'b1;
            default:             rsp_valid = 1'b0;
        endcase
    end

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = '0;

    ctlreg_flush u_flush (
        .clk       (clk),
        .rst       (rst),
        .fire      (wr_ok && attr.flush != FL_NONE),
        .sel       (attr.flush),
        .va        (req_wdata),
        .dtb_asn   (bank[SLOT_W'(CR_DTB_ASN)][DATA_W-1:DATA_W-ASN_W]),
        .itb_asn   (bank[SLOT_W'(CR_ITB_ASN)][4+ASN_W-1:4]),
        .dtb_all   (dtb_flush_all),
        .dtb_proc  (dtb_flush_proc),
        .dtb_one   (dtb_flush_one),
        .itb_all   (itb_flush_all),
        .itb_proc  (itb_flush_proc),
        .itb_one   (itb_flush_one),
        .flush_va  (flush_va),
        .flush_asn (flush_asn)
    );

endmodule

module ctlreg_bank_chk
    import ctlreg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [IDX_W-1:0]  req_idx,
    input logic              req_write,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_fault,
    input logic              dtb_flush_all,
    input logic              dtb_flush_proc,
    input logic              dtb_flush_one,
    input logic              itb_flush_all,
    input logic              itb_flush_proc,
    input logic              itb_flush_one,
    input logic [DATA_W-1:0] flush_va
);

    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid == $past(req_valid)));

    // R9
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_rdata == '0));

    // R10
    bad_index_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_idx >= IDX_W'(NUM_REGS)) |=> (rsp_valid && rsp_fault));

    // R8
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_idx >= CR_IRQ_ID && req_idx <= CR_DPTE_TMP)
        |=> rsp_fault);

    // R11
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dtb_flush_all, dtb_flush_proc, dtb_flush_one,
                  itb_flush_all, itb_flush_proc, itb_flush_one}));

    // R11
    dtb_all_src_chk: assert property (@(posedge clk) disable iff (rst)
        dtb_flush_all |-> $past(req_valid && req_write && req_idx == CR_DTB_INV_ALL));

    // R12
    itb_one_src_chk: assert property (@(posedge clk) disable iff (rst)
        itb_flush_one |-> ($past(req_valid && req_write && req_idx == CR_ITB_INV_ONE)
                           && flush_va == $past(req_wdata)));

endmodule

bind ctlreg_bank ctlreg_bank_chk u_chk (.*);

// File: tb/ctlreg_bank_test.sv
module ctlreg_bank_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [6:0]  req_idx = '0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [31:0] cycles_lo = '0;
    logic        rsp_valid, rsp_fault;
    logic [63:0] rsp_rdata, flush_va;
    logic        dtb_flush_all, dtb_flush_proc, dtb_flush_one;
    logic        itb_flush_all, itb_flush_proc, itb_flush_one;
    logic [6:0]  flush_asn;

    always #10 clk = ~clk;

    ctlreg_bank uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
        .req_write(req_write), .req_wdata(req_wdata), .cycles_lo(cycles_lo),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
        .dtb_flush_all(dtb_flush_all), .dtb_flush_proc(dtb_flush_proc),
        .dtb_flush_one(dtb_flush_one), .itb_flush_all(itb_flush_all),
        .itb_flush_proc(itb_flush_proc), .itb_flush_one(itb_flush_one),
        .flush_va(flush_va), .flush_asn(flush_asn)
    );

    int total = 0;
    int fails = 0;
    bit done  = 0;

    logic [63:0]  mdl [0:127];
    logic [142:0] exp_vec;
    string        exp_tag;

    // 0 unmapped, 1 read/write, 2 read-only, 3 write-only
    function automatic int access_class(int idx);
        if (idx <= 28) return 1;
        if (idx == 29) return 3;
        if (idx <= 34) return 1;
        if (idx <= 38) return 2;
        if (idx <= 41) return 3;
        if (idx <= 45) return 1;
        if (idx <= 51) return 3;
        return 0;
    endfunction

    function automatic logic [142:0] observed();
        return {rsp_valid, rsp_fault, rsp_rdata,
                dtb_flush_all, dtb_flush_proc, dtb_flush_one,
                itb_flush_all, itb_flush_proc, itb_flush_one,
                flush_va, flush_asn};
    endfunction

    task automatic compare();
        logic [142:0] got = observed();
        total++;
        if (got !== exp_vec) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", exp_tag, got, exp_vec);
        end
    endtask

    task automatic step(input bit v, input int idx, input bit wr,
                        input logic [63:0] d, input string tag);
        logic        flt = 1'b0;
        logic [63:0] rd = '0, va = '0;
        logic [5:0]  stb = '0;
        logic [6:0]  asn = '0;
        int          cls;
        @(negedge clk);
        compare();
        cycles_lo = cycles_lo + 32'h0101_0107;
        if (v) begin
            cls = access_class(idx);
            if (!wr) begin
                if (cls == 1 || cls == 2)
                    rd = (idx == 33) ? {mdl[33][63:32], cycles_lo} : mdl[idx];
                else flt = 1'b1;
            end else if (cls == 0 || cls == 2) begin
                flt = 1'b1;
            end else begin
                case (idx)
                    24: mdl[idx] = d & 64'hFFFF_FFFF_FFFF_FFFD;
                    25, 26: mdl[idx] = d & 64'hF;
                    27: mdl[idx] = d & 64'h1F;
                    28, 29: mdl[idx] = d & 64'h18;
                    30: mdl[idx] = d & 64'h7FFF0;
                    31, 32: mdl[idx] = 64'h0;
                    34: mdl[idx] = 64'h1;
                    42: mdl[idx] = d & 64'hFE00_0000_0000_0000;
                    43: mdl[idx] = d & 64'h7F0;
                    44, 45: mdl[idx] = d & 64'h3F;
                    46: begin mdl[idx] = 0; stb = 6'b100000; end
                    47: begin mdl[idx] = 0; stb = 6'b010000; end
                    48: begin mdl[idx] = 0; stb = 6'b000100; end
                    49: begin mdl[idx] = 0; stb = 6'b000010; end
                    50: begin mdl[idx] = d; stb = 6'b001000; va = d; asn = mdl[42][63:57]; end
                    51: begin mdl[idx] = d; stb = 6'b000001; va = d; asn = mdl[43][10:4]; end
                    default: mdl[idx] = d;
                endcase
            end
        end
        exp_vec   = {v, flt, rd, stb, va, asn};
        exp_tag   = tag;
        req_valid = v;
        req_idx   = 7'(idx);
        req_write = wr;
        req_wdata = d;
    endtask

    task automatic wr(input int idx, input logic [63:0] d, input string tag);
        step(1'b1, idx, 1'b1, d, tag);
    endtask

    task automatic rd(input int idx, input string tag);
        step(1'b1, idx, 1'b0, 64'h0, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 0, 1'b0, 64'h0, tag);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mdl[i] = '0;
        exp_vec = '0;
        exp_tag = "R1 reset state";
        repeat (3) @(negedge clk);
        rst = 1'b0;

        idle("R1 outputs after reset");
        rd(0, "R1 scratch zero after reset");
        rd(42, "R1 asn zero after reset");
        idle("R2 idle gives no response");

        wr(0, 64'hDEAD_BEEF_CAFE_F00D, "R2 write response");
        rd(0, "R3 scratch 0 full store");
        wr(23, 64'hFFFF_FFFF_FFFF_FFFF, "R3 scratch 23 write");
        rd(23, "R3 scratch 23 full store");
        wr(11, 64'h0123_4567_89AB_CDEF, "R3 scratch 11 write");
        rd(11, "R3 scratch 11 back-to-back");
        rd(0, "R3 scratch 0 unchanged");

        wr(24, '1, "R4 exc pc write");        rd(24, "R4 exc pc bit1 clear");
        wr(25, '1, "R4 trap req write");      rd(25, "R4 trap req mask");
        wr(26, 64'hA5, "R4 trap en write");   rd(26, "R4 trap en mask");
        wr(27, '1, "R4 level write");         rd(27, "R4 level mask");
        wr(28, '1, "R4 mode write");          rd(28, "R4 mode mask");
        wr(30, '1, "R4 sw irq write");        rd(30, "R4 sw irq mask");
        wr(42, '1, "R4 dtb asn write");       rd(42, "R4 dtb asn mask");
        wr(43, 64'h5A5, "R4 itb asn write");  rd(43, "R4 itb asn mask");
        wr(44, '1, "R4 cache mode write");    rd(44, "R4 cache mode mask");
        wr(45, 64'hC3, "R4 maf mode write");  rd(45, "R4 maf mode mask");

        wr(31, '1, "R5 exc sum write");       rd(31, "R5 exc sum cleared");
        wr(32, 64'h55, "R5 exc mask write");  rd(32, "R5 exc mask cleared");

        wr(33, 64'hAAAA_5555_1234_5678, "R6 cycle write");
        rd(33, "R6 cycle merged read");
        idle("R6 idle");
        rd(33, "R6 cycle live low changes");

        wr(34, 64'h0, "R7 cycle ctl write zero data");
        rd(34, "R7 cycle ctl reads one");

        wr(35, '1, "R8 irq id write fault");  rd(35, "R8 irq id unchanged");
        wr(36, '1, "R8 mm stat write fault"); rd(36, "R8 mm stat unchanged");
        wr(38, '1, "R8 pte tmp write fault"); rd(38, "R8 pte tmp unchanged");

        wr(29, '1, "R9 alt mode write");      rd(29, "R9 alt mode read fault");
        wr(39, '1, "R9 hwi clr write");       rd(39, "R9 hwi clr read fault");
        rd(40, "R9 dc flush read fault");
        rd(46, "R9 invalidate read fault");

        rd(52, "R10 read idx 52");
        wr(52, '1, "R10 write idx 52");
        wr(127, '1, "R10 write idx 127");
        rd(127, "R10 read idx 127");
        rd(0, "R10 state unchanged");

        wr(46, '1, "R11 dtb all");
        wr(47, '1, "R11 dtb proc back-to-back");
        wr(48, '1, "R11 itb all");
        wr(49, '1, "R11 itb proc");
        idle("R11 strobe single cycle");
        idle("R11 strobes low");

        wr(50, 64'h0000_7FFF_0000_2000, "R12 dtb single");
        idle("R12 dtb single strobe");
        wr(51, 64'h1234_0000_0000_4000, "R12 itb single");
        wr(51, 64'h0, "R12 itb single repeat");
        idle("R12 itb single strobe");
        wr(42, 64'h0200_0000_0000_0000, "R12 change dtb asn");
        wr(50, 64'hFFFF_0000, "R12 dtb single new asn");
        idle("R12 strobe with new asn");

        rst = 1'b1;
        for (int i = 0; i < 128; i++) mdl[i] = '0;
        @(negedge clk);
        exp_vec = '0;
        exp_tag = "R1 reset mid-run";
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        idle("R1 after second reset");
        rd(0, "R1 scratch cleared by reset");
        rd(24, "R1 exc pc cleared by reset");
        idle("R1 final");
        @(negedge clk);
        compare();

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule